// File: doc/BRIEF.md
# Spindle Stop Park-and-Brake Sequencer

This block orders the two phases of a spindle stop. A host raises a stop request. The block then enables the park circuit and lets it work for a fixed number of falling zero crossings of the phase A back-EMF comparator. The delay is counted in motor crossings, not in clock cycles. Once the last crossing has been counted, park is released and braking is enabled. Braking stays on for as long as the request is held. Dropping the request returns the block to idle and clears the crossing count.

Next to the sequencer sits a five-bit status word that a host fetches through a register port. Some of its flags are live and some are sticky. The sticky flags clear when the word is read, and a set event that lands in the same cycle as the read survives it.

Top module: `spin_stop_seq`

## Requirements
- R1: While reset is active (rst_n low), park_en, brake_en and every bit of stat_word are 0.
- R2: A request (stop_req high) seen in idle asserts park_en from the next clock on, and stat_word bit 0 (parking) follows park_en.
- R3: The park interval ends on exactly the NCROSS-th (default 128) 1-to-0 transition of phase A after the request. No earlier count ends it, and rising edges are never counted. Phase A passes through a two-flop synchroniser first.
- R4: Phase A crossings that happen while idle are not counted. A sequence started afterwards still needs the full NCROSS crossings.
- R5: When the interval completes, park_en falls and brake_en rises on the same clock. Sticky bit 1 (park ended) and sticky bit 2 (brake started) set on that clock too.
- R6: Withdrawing the request during park or brake deasserts both enables on the next clock and clears the crossing count. Withdrawal during park sets bit 1 but not bit 2.
- R7: brake_en stays high for as long as the request is held, whatever phase A does.
- R8: stat_word bit 3 (current limit) sets on a clock where ilim_cmp is high and stays set after the comparator falls. A status read (stat_rd high for one clock) clears it.
- R9: If a sticky bit's set condition and a status read fall on the same clock, the bit stays set.
- R10: stat_word bit 4 follows therm_flag one clock later, and a status read does not clear it.
- R11: A status read clears sticky bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| stop_req | input | 1 | Park/brake request level |
| pha_cmp | input | 1 | Phase A back-EMF comparator, asynchronous |
| ilim_cmp | input | 1 | Spindle current-limit comparator |
| therm_flag | input | 1 | Thermal shutdown indication |
| stat_rd | input | 1 | Status read strobe, one clock per read |
| park_en | output | 1 | Park circuit enable |
| brake_en | output | 1 | Brake enable |
| stat_word | output | 5 | Status: 0 parking, 1 park ended, 2 brake started, 3 current limit, 4 thermal |

## Verification
The bench stops one crossing short of the terminal count and then supplies that crossing. A design with an off-by-one in the count would brake a crossing early or late. It also feeds crossings while idle and withdraws the request mid-park. A block that counted in idle, or failed to clear its counter, would then brake too soon on the next request. A current-limit pulse that coincides with a read catches a status bank where the clear beats the set and the event is lost. Further checks catch a read that wrongly clears the live thermal bit, or a brake that drops while the request is still held.

// File: rtl/stop_seq_pkg.sv
// Shared types for the spindle stop sequencer.
// Assumes: status bit positions are fixed, because the host decodes them.
package stop_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PARK  = 2'd1,
        ST_BRAKE = 2'd2
    } seq_state_t;

    localparam int SB_PARKING  = 0;
    localparam int SB_PARK_END = 1;
    localparam int SB_BRK_GO   = 2;
    localparam int SB_ILIM     = 3;
    localparam int SB_THERM    = 4;
    localparam int SB_W        = 5;
endpackage

// File: rtl/ph_edge.sv
// Synchronises an asynchronous comparator and flags its falling edges.
// Assumes: STAGES >= 2. fall is high for one clock per 1-to-0 transition
// of the synchronised signal.
module ph_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic fall
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_sync
        if (i == 0) begin : g_first
            // First stage: capture the asynchronous input.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= din;
            end
        end else begin : g_next
            // Later stages: resolve metastability.
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[i] <= 1'b0;
                else        sync_q[i] <= sync_q[i-1];
            end
        end
    end

    // Previous synchronised value, used for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    // Falling edge: was high, now low.
    always_comb fall = last_q & ~sync_q[STAGES-1];
endmodule

// File: rtl/cross_ctr.sv
// Counts crossing events up to NCROSS.
// Assumes: clr has priority over inc, and inc never comes once the count
// has reached NCROSS.
module cross_ctr #(
    parameter int NCROSS = 128
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        clr,
    input  logic                        inc,
    output logic [$clog2(NCROSS+1)-1:0] cnt,
    output logic                        last
);
    localparam int CW = $clog2(NCROSS+1);
    localparam logic [CW-1:0] LAST_VAL = CW'(NCROSS - 1);

    logic [CW-1:0] cnt_q;

    // Count register: cleared by reset or clr, advanced by inc.
    always_ff @(posedge clk) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else if (inc) cnt_q <= cnt_q + 1'b1;
    end

    // The next counted event is the terminal one.
    always_comb last = (cnt_q == LAST_VAL);
    assign cnt = cnt_q;
endmodule

// File: rtl/stop_fsm.sv
// Idle -> park -> brake sequencer for a level stop request.
// Assumes: fall is a one-clock pulse per phase A falling crossing, and
// last is high while the counter is one short of its end.
module stop_fsm
    import stop_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req,
    input  logic       fall,
    input  logic       last,
    output seq_state_t state,
    output logic       park_en,
    output logic       brake_en,
    output logic       ctr_clr,
    output logic       ctr_inc,
    output logic       park_end_ev,
    output logic       brake_go_ev
);
    seq_state_t state_q, state_d;
    logic       done;

    // The terminal crossing arrives while parking with the request held.
    always_comb done = (state_q == ST_PARK) && req && fall && last;

    // Next-state decode.
    always_comb begin
        state_d = state_q;
        case (state_q)
            ST_IDLE:  if (req) state_d = ST_PARK;
            ST_PARK:  if (!req) state_d = ST_IDLE;
                      else if (done) state_d = ST_BRAKE;
            ST_BRAKE: if (!req) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Outputs, counter control and status events.
    always_comb begin
        park_en     = (state_q == ST_PARK);
        brake_en    = (state_q == ST_BRAKE);
        ctr_clr     = (state_q == ST_IDLE);
        ctr_inc     = (state_q == ST_PARK) && req && fall;
        park_end_ev = (state_q == ST_PARK) && (!req || done);
        brake_go_ev = done;
    end

    assign state = state_q;
endmodule

// File: rtl/stat_bank.sv
// Host-visible status word. It holds live and sticky flags, and a read
// clears the sticky ones.
// Assumes: rd is high for one clock per read. A set on the same clock wins.
module stat_bank
    import stop_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            parking,
    input  logic            park_end_ev,
    input  logic            brake_go_ev,
    input  logic            ilim,
    input  logic            therm,
    input  logic            rd,
    output logic [SB_W-1:0] word
);
    localparam int NSTICKY = 3;

    logic [NSTICKY-1:0] set_v;
    logic [NSTICKY-1:0] sticky_q;
    logic               therm_q;

    // Set conditions of the sticky bits: park end, brake start, current limit.
    always_comb set_v = {ilim, brake_go_ev, park_end_ev};

    for (genvar i = 0; i < NSTICKY; i++) begin : g_sticky
        // One sticky flag: a set beats the read clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        sticky_q[i] <= 1'b0;
            else if (set_v[i]) sticky_q[i] <= 1'b1;
            else if (rd)       sticky_q[i] <= 1'b0;
        end
    end

    // Live thermal copy, not affected by reads.
    always_ff @(posedge clk) begin
        if (!rst_n) therm_q <= 1'b0;
        else        therm_q <= therm;
    end

    // Assemble the status word.
    always_comb begin
        word              = '0;
        word[SB_PARKING]  = parking;
        word[SB_PARK_END] = sticky_q[0];
        word[SB_BRK_GO]   = sticky_q[1];
        word[SB_ILIM]     = sticky_q[2];
        word[SB_THERM]    = therm_q;
    end
endmodule

// File: rtl/spin_stop_seq.sv
// Top level of the spindle stop sequencer. It counts park time in phase A
// falling crossings, then brakes, and reports progress in a status word.
// Assumes: stop_req, ilim_cmp, therm_flag and stat_rd are synchronous to clk.
module spin_stop_seq
    import stop_seq_pkg::*;
#(
    parameter int NCROSS      = 128,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            stop_req,
    input  logic            pha_cmp,
    input  logic            ilim_cmp,
    input  logic            therm_flag,
    input  logic            stat_rd,
    output logic            park_en,
    output logic            brake_en,
    output logic [SB_W-1:0] stat_word
);
    localparam int CW = $clog2(NCROSS+1);

    logic          fall, last, ctr_clr, ctr_inc, park_end_ev, brake_go_ev;
    logic [CW-1:0] cnt;
    seq_state_t    state;

    ph_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk(clk), .rst_n(rst_n), .din(pha_cmp), .fall(fall)
    );

    cross_ctr #(.NCROSS(NCROSS)) u_ctr (
        .clk(clk), .rst_n(rst_n), .clr(ctr_clr), .inc(ctr_inc),
        .cnt(cnt), .last(last)
    );

    stop_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .req(stop_req), .fall(fall), .last(last),
        .state(state), .park_en(park_en), .brake_en(brake_en),
        .ctr_clr(ctr_clr), .ctr_inc(ctr_inc),
        .park_end_ev(park_end_ev), .brake_go_ev(brake_go_ev)
    );

    stat_bank u_stat (
        .clk(clk), .rst_n(rst_n), .parking(park_en),
        .park_end_ev(park_end_ev), .brake_go_ev(brake_go_ev),
        .ilim(ilim_cmp), .therm(therm_flag), .rd(stat_rd), .word(stat_word)
    );
endmodule

// File: rtl/spin_stop_seq_chk.sv
// Property checker for spin_stop_seq. It is attached by bind and only
// observes the block.
module spin_stop_seq_chk #(
    parameter int NCROSS = 128
) (
    input logic                        clk,
    input logic                        rst_n,
    input logic                        stop_req,
    input logic                        ilim_cmp,
    input logic                        therm_flag,
    input logic                        stat_rd,
    input logic                        park_en,
    input logic                        brake_en,
    input logic [4:0]                  stat_word,
    input logic [$clog2(NCROSS+1)-1:0] cnt
);
    AST_ENABLES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(park_en && brake_en)); // R5
    AST_BRAKE_AFTER_PARK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(brake_en) |-> $past(park_en)); // R5
    AST_PARK_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        stat_word[0] == park_en); // R2
    AST_WITHDRAW_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_req |=> !park_en && !brake_en); // R6
    AST_BRAKE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        brake_en && stop_req |=> brake_en); // R7
    AST_ILIM_SET: assert property (@(posedge clk) disable iff (!rst_n)
        ilim_cmp |=> stat_word[3]); // R9
    AST_ILIM_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && !ilim_cmp |=> !stat_word[3]); // R8
    AST_THERM_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        therm_flag |=> stat_word[4]); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= ($clog2(NCROSS+1))'(NCROSS)); // R3
endmodule

bind spin_stop_seq spin_stop_seq_chk #(.NCROSS(NCROSS)) u_chk (
    .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .ilim_cmp(ilim_cmp),
    .therm_flag(therm_flag), .stat_rd(stat_rd), .park_en(park_en),
    .brake_en(brake_en), .stat_word(stat_word), .cnt(u_ctr.cnt)
);

// File: tb/sim_spin_stop_seq.sv
// Directed bench for spin_stop_seq: one task per scenario.
module sim_spin_stop_seq;
    localparam int N = 128;

    logic       clk = 1'b0;
    logic       rst_n, stop_req, pha_cmp, ilim_cmp, therm_flag, stat_rd;
    logic       park_en, brake_en;
    logic [4:0] stat_word;
    int         n_chk = 0;
    int         n_bad = 0;

    always #5 clk = ~clk;

    spin_stop_seq u0 (
        .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .pha_cmp(pha_cmp),
        .ilim_cmp(ilim_cmp), .therm_flag(therm_flag), .stat_rd(stat_rd),
        .park_en(park_en), .brake_en(brake_en), .stat_word(stat_word)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
        end
    endtask

    // One full phase A period. The falling edge is counted before it returns.
    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            pha_cmp = 1'b1; repeat (4) @(negedge clk);
            pha_cmp = 1'b0; repeat (4) @(negedge clk);
        end
    endtask

    // Read the status word: sample while the strobe is high, then drop it.
    task automatic rd_stat(output logic [4:0] v);
        stat_rd = 1'b1; v = stat_word;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    task automatic do_reset;
        rst_n = 1'b0; stop_req = 0; pha_cmp = 0; ilim_cmp = 0;
        therm_flag = 0; stat_rd = 0;
        repeat (3) @(negedge clk);
        chk("R1 park_en", park_en, 0);
        chk("R1 brake_en", brake_en, 0);
        chk("R1 stat_word", stat_word, 0);
        rst_n = 1'b1; @(negedge clk);
    endtask

    task automatic t_full_seq;
        logic [4:0] v;
        stop_req = 1'b1; @(negedge clk);
        chk("R2 park_en", park_en, 1);
        chk("R2 parking bit", stat_word[0], 1);
        pulse(N-1);
        chk("R3 no brake before last crossing", brake_en, 0);
        chk("R3 still parking", park_en, 1);
        pulse(1);
        chk("R5 brake_en", brake_en, 1);
        chk("R5 park_en low", park_en, 0);
        chk("R5 status", stat_word[2:0], 3'b110);
        pulse(5);
        repeat (20) @(negedge clk);
        chk("R7 brake held", brake_en, 1);
        rd_stat(v);
        chk("R11 read value", v[2:1], 2'b11);
        chk("R11 sticky cleared", stat_word[2:1], 2'b00);
        stop_req = 1'b0; @(negedge clk);
        chk("R6 brake released", brake_en, 0);
    endtask

    task automatic t_idle_cross;
        logic [4:0] v;
        pulse(50);
        chk("R4 idle stays idle", {park_en, brake_en}, 2'b00);
        stop_req = 1'b1; @(negedge clk);
        pulse(N-1);
        chk("R4 idle crossings not counted", brake_en, 0);
        pulse(1);
        chk("R4 brake after full count", brake_en, 1);
        stop_req = 1'b0; @(negedge clk);
        rd_stat(v);
    endtask

    task automatic t_withdraw;
        logic [4:0] v;
        stop_req = 1'b1; @(negedge clk);
        pulse(100);
        stop_req = 1'b0; @(negedge clk);
        chk("R6 idle after withdraw", {park_en, brake_en}, 2'b00);
        chk("R6 park end without brake", stat_word[2:1], 2'b01);
        rd_stat(v);
        stop_req = 1'b1; @(negedge clk);
        pulse(N-1);
        chk("R6 counter cleared", brake_en, 0);
        pulse(1);
        chk("R6 full count after restart", brake_en, 1);
        stop_req = 1'b0; @(negedge clk);
        rd_stat(v);
    endtask

    task automatic t_ilim;
        logic [4:0] v;
        ilim_cmp = 1'b1; @(negedge clk);
        ilim_cmp = 1'b0; @(negedge clk);
        chk("R8 ilim sticky", stat_word[3], 1);
        // The read coincides with a new current-limit event.
        ilim_cmp = 1'b1; stat_rd = 1'b1; @(negedge clk);
        ilim_cmp = 1'b0; stat_rd = 1'b0;
        chk("R9 set wins over read", stat_word[3], 1);
        rd_stat(v);
        chk("R8 read value", v[3], 1);
        chk("R8 cleared by read", stat_word[3], 0);
    endtask

    task automatic t_therm;
        logic [4:0] v;
        therm_flag = 1'b1; @(negedge clk);
        chk("R10 thermal shown", stat_word[4], 1);
        rd_stat(v);
        chk("R10 read keeps thermal", stat_word[4], 1);
        therm_flag = 1'b0; @(negedge clk);
        chk("R10 thermal follows", stat_word[4], 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        t_full_seq();
        t_idle_cross();
        t_withdraw();
        t_ilim();
        t_therm();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule